// File: doc/BRIEF.md
# CAN frame error checker

This block sits beside a CAN controller and observes the bus one sampled bit at a time. A strobe marks each bit. The block decodes a standard data or remote frame with an 11-bit identifier. It removes stuff bits, follows the frame through its fields and reports every protocol violation it finds. When the local node is driving the bus, the block also compares the bit that was sent with the bit read back.

Each detected condition appears twice. It drives a one-cycle pulse on an event vector, and it sets a sticky flag in a status byte that uses the same bit layout. Software clears the status byte by writing ones to a clear mask. The received length code is always passed out, including when it differs from the length the host expected. In that case the block raises a warning but still accepts the frame. After an error, the block stays quiet until the bus has been idle long enough, and only then looks for a new frame start.

Top module: `can_frame_checker`

## Requirements
- R1: A bus level is 0 for dominant and 1 for recessive, and a bit is taken only in a cycle where `bit_valid` is high. While idle, recessive bits are ignored, and a dominant bit starts a frame. The following fields are taken in this order: 11 identifier bits, the RTR bit, the IDE bit, r0, a 4-bit DLC (most significant bit first), the data, and then 15 CRC bits.
- R2: From the start bit through the last CRC bit, a bit that follows five equal bits is a stuff bit. If it has the opposite level, it is removed. If it has the same level, the block raises a stuff error on event/status bit 3. No bit after the last CRC bit is destuffed.
- R3: A CRC with polynomial x^15+x^14+x^10+x^8+x^7+x^4+x^3+1 is computed from a cleared register over the destuffed bits, from the start bit to the end of the data. If it differs from the received CRC field, a CRC error is raised on bit 2 at the last CRC bit.
- R4: If the CRC delimiter, the acknowledge delimiter or any of the 7 end-of-frame bits is dominant, a form error is raised on bit 1.
- R5: If the acknowledge slot is recessive, an acknowledge error is raised on bit 0.
- R6: When `tx_active` is high and `tx_bit` differs from `rx_bit` on a frame bit, a bit error is raised on bit 4. Two cases are exempt: a sent recessive read as dominant inside the identifier or RTR bits, and any bit in the acknowledge slot.
- R7: When the last DLC bit arrives, `rx_dlc` takes the received DLC. If it differs from `exp_dlc`, a warning is raised on bit 7, and decoding of the frame continues.
- R8: The data field holds min(DLC, 8) bytes when RTR is dominant, and no bytes when RTR is recessive.
- R9: When the last end-of-frame bit arrives and no error was found, the block signals a completed frame. It raises transmit OK on bit 6 if `tx_active` is high on that bit, and receive OK on bit 5 otherwise. It never raises both.
- R10: `evt` pulses for exactly one cycle. The pulse comes in the cycle after the strobe of the bit that caused it. The matching `status` bit is set in that same cycle and stays set.
- R11: A one in `clr_mask` clears the matching status bit in the next cycle. A new event on the same bit in that cycle wins over the clear. A zero in `clr_mask` leaves the bit unchanged.
- R12: After any error on bits 0 to 4, the block ignores the bus until it sees 11 consecutive recessive bits. A dominant bit restarts that count. Only after the count completes is a dominant bit taken as a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_valid | input | 1 | One-cycle strobe per sampled bus bit |
| rx_bit | input | 1 | Bus level read back (0 = dominant) |
| tx_active | input | 1 | The local node is driving the current bit |
| tx_bit | input | 1 | Level the local node sent for the current bit |
| exp_dlc | input | 4 | Length code the host expects |
| clr_mask | input | 8 | Write-one-to-clear mask for the status byte |
| evt | output | 8 | One-cycle event pulses, same layout as `status` |
| status | output | 8 | Sticky flags: 7 DLC warning, 6 transmit OK, 5 receive OK, 4 bit, 3 stuff, 2 CRC, 1 form, 0 acknowledge |
| rx_dlc | output | 4 | Last received length code |

## Verification
The properties assume that `bit_valid` is low while reset is asserted, so that nothing reaches the status byte before the event register leaves reset. They also assume that `tx_bit`, `tx_active` and `rx_bit` are only meaningful in a strobe cycle. The stimulus drives every bus bit as a single-cycle strobe followed by an idle cycle. All pins change at the falling edge, and the strobe stays low for the whole reset period. The stimulus builds every frame with correct stuffing and a correct CRC and adds exactly one deliberate fault. As a result, each expected status byte carries a single cause.

// File: rtl/can_chk_pkg.sv
package can_chk_pkg;

    typedef enum logic [3:0] {
        FLD_IDLE,
        FLD_ARB,
        FLD_CTRL,
        FLD_DATA,
        FLD_CRC,
        FLD_CRC_DLM,
        FLD_ACK,
        FLD_ACK_DLM,
        FLD_EOF,
        FLD_RECOVER
    } fld_e;

    localparam int EV_ACK   = 0;
    localparam int EV_FORM  = 1;
    localparam int EV_CRC   = 2;
    localparam int EV_STUFF = 3;
    localparam int EV_BIT   = 4;
    localparam int EV_RXOK  = 5;
    localparam int EV_TXOK  = 6;
    localparam int EV_DLCW  = 7;

endpackage

// File: rtl/can_destuff.sv
module can_destuff #(
    parameter int RUN_MAX = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic start,
    input  logic bit_in,
    output logic is_stuff,
    output logic run_err
);
    localparam int RW = $clog2(RUN_MAX + 1);
    localparam logic [RW-1:0] RUN_TOP = RW'(RUN_MAX);
    localparam logic [RW-1:0] RUN_ONE = RW'(1);

    typedef struct packed {
        logic          last;
        logic [RW-1:0] run;
    } ds_t;

    ds_t ds_q, ds_d;

    always_comb begin
        ds_d     = ds_q;
        is_stuff = 1'b0;
        run_err  = 1'b0;
        if (strobe) begin
            if (start) begin
                ds_d.last = bit_in;
                ds_d.run  = RUN_ONE;
            end else if (ds_q.run == RUN_TOP) begin
                if (bit_in == ds_q.last) begin
                    run_err = 1'b1;
                end else begin
                    is_stuff  = 1'b1;
                    ds_d.last = bit_in;
                    ds_d.run  = RUN_ONE;
                end
            end else if (bit_in == ds_q.last) begin
                ds_d.run = ds_q.run + RUN_ONE;
            end else begin
                ds_d.last = bit_in;
                ds_d.run  = RUN_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ds_q <= '0;
        else        ds_q <= ds_d;
    end
endmodule

// File: rtl/can_crc15.sv
module can_crc15 #(
    parameter int          WIDTH = 15,
    parameter logic [14:0] POLY  = 15'h4599
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic feed,
    input  logic bit_in,
    output logic zero_next
);
    logic [WIDTH-1:0] crc_q, crc_d, stepped;
    logic             fb;

    always_comb begin
        fb        = bit_in ^ crc_q[WIDTH-1];
        stepped   = {crc_q[WIDTH-2:0], 1'b0} ^ (fb ? WIDTH'(POLY) : '0);
        zero_next = (stepped == '0);
        crc_d     = crc_q;
        if (clear)     crc_d = '0;
        else if (feed) crc_d = stepped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end
endmodule

// File: rtl/can_frame_checker.sv
module can_frame_checker
    import can_chk_pkg::*;
#(
    parameter int          ID_BITS   = 11,
    parameter int          MAX_BYTES = 8,
    parameter int          CRC_W     = 15,
    parameter logic [14:0] CRC_POLY  = 15'h4599,
    parameter int          STUFF_RUN = 5,
    parameter int          EOF_LEN   = 7,
    parameter int          IDLE_LEN  = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_valid,
    input  logic       rx_bit,
    input  logic       tx_active,
    input  logic       tx_bit,
    input  logic [3:0] exp_dlc,
    input  logic [7:0] clr_mask,
    output logic [7:0] evt,
    output logic [7:0] status,
    output logic [3:0] rx_dlc
);
    localparam int MAX_DATA_BITS = MAX_BYTES * 8;
    localparam int CNT_MAX       = (MAX_DATA_BITS > 64) ? MAX_DATA_BITS : 64;
    localparam int CNT_W         = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] ARB_LAST  = CNT_W'(ID_BITS);
    localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(5);
    localparam logic [CNT_W-1:0] CRC_LAST  = CNT_W'(CRC_W - 1);
    localparam logic [CNT_W-1:0] EOF_LAST  = CNT_W'(EOF_LEN - 1);
    localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_LEN - 1);

    typedef struct packed {
        fld_e             st;
        logic [CNT_W-1:0] cnt;
        logic             rtr;
        logic [2:0]       dlc_sh;
        logic [CNT_W-1:0] dlen;
        logic [7:0]       evt;
    } ctl_t;

    ctl_t             q, d;
    logic [7:0]       status_q, status_d;
    logic [3:0]       rx_dlc_q, rx_dlc_d;
    logic [7:0]       ev;
    logic [3:0]       dlc_full;
    logic [CNT_W-1:0] nbits;
    logic             sof, stuffed, data_bit, in_frame, arb_loss, eof_done;
    logic             ds_stuff, ds_err, crc_zero;

    assign sof     = bit_valid && (q.st == FLD_IDLE) && !rx_bit;
    assign stuffed = (q.st == FLD_ARB) || (q.st == FLD_CTRL) ||
                     (q.st == FLD_DATA) || (q.st == FLD_CRC);

    can_destuff #(.RUN_MAX(STUFF_RUN)) u_destuff (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (bit_valid && (stuffed || sof)),
        .start    (sof),
        .bit_in   (rx_bit),
        .is_stuff (ds_stuff),
        .run_err  (ds_err)
    );

    assign data_bit = bit_valid && stuffed && !ds_stuff && !ds_err;

    can_crc15 #(.WIDTH(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (q.st == FLD_IDLE),
        .feed      (data_bit),
        .bit_in    (rx_bit),
        .zero_next (crc_zero)
    );

    always_comb begin
        d        = q;
        ev       = '0;
        dlc_full = {q.dlc_sh, rx_bit};
        nbits    = '0;
        eof_done = 1'b0;
        in_frame = (q.st != FLD_RECOVER) && ((q.st != FLD_IDLE) || !rx_bit);
        arb_loss = (q.st == FLD_ARB) && tx_bit && !rx_bit;
        rx_dlc_d = rx_dlc_q;
        if (bit_valid) begin
            if (tx_active && in_frame && (tx_bit != rx_bit) && !arb_loss && (q.st != FLD_ACK))
                ev[EV_BIT] = 1'b1;
            ev[EV_STUFF] = ds_err;
            unique case (q.st)
                FLD_IDLE: if (!rx_bit) begin d.st = FLD_ARB; d.cnt = '0; end
                FLD_ARB: if (data_bit) begin
                    if (q.cnt == ARB_LAST) begin
                        d.rtr = rx_bit; d.st = FLD_CTRL; d.cnt = '0;
                    end else d.cnt = q.cnt + ONE;
                end
                FLD_CTRL: if (data_bit) begin
                    if (q.cnt == CTRL_LAST) begin
                        rx_dlc_d = dlc_full;
                        if (dlc_full != exp_dlc) ev[EV_DLCW] = 1'b1;
                        if (!q.rtr)
                            nbits = (32'(dlc_full) > MAX_BYTES) ? CNT_W'(MAX_DATA_BITS)
                                                                : CNT_W'({dlc_full, 3'b000});
                        d.dlen = nbits;
                        d.cnt  = '0;
                        d.st   = (nbits == '0) ? FLD_CRC : FLD_DATA;
                    end else begin
                        d.dlc_sh = {q.dlc_sh[1:0], rx_bit};
                        d.cnt    = q.cnt + ONE;
                    end
                end
                FLD_DATA: if (data_bit) begin
                    if (q.cnt == q.dlen - ONE) begin d.st = FLD_CRC; d.cnt = '0; end
                    else d.cnt = q.cnt + ONE;
                end
                FLD_CRC: if (data_bit) begin
                    if (q.cnt == CRC_LAST) begin
                        if (!crc_zero) ev[EV_CRC] = 1'b1;
                        d.st = FLD_CRC_DLM;
                    end else d.cnt = q.cnt + ONE;
                end
                FLD_CRC_DLM: begin
                    if (!rx_bit) ev[EV_FORM] = 1'b1;
                    d.st = FLD_ACK;
                end
                FLD_ACK: begin
                    if (rx_bit) ev[EV_ACK] = 1'b1;
                    d.st = FLD_ACK_DLM;
                end
                FLD_ACK_DLM: begin
                    if (!rx_bit) ev[EV_FORM] = 1'b1;
                    d.st  = FLD_EOF;
                    d.cnt = '0;
                end
                FLD_EOF: begin
                    if (!rx_bit) ev[EV_FORM] = 1'b1;
                    else if (q.cnt == EOF_LAST) begin eof_done = 1'b1; d.st = FLD_IDLE; end
                    else d.cnt = q.cnt + ONE;
                end
                FLD_RECOVER: begin
                    if (!rx_bit)                d.cnt = '0;
                    else if (q.cnt == IDLE_LAST) d.st = FLD_IDLE;
                    else                         d.cnt = q.cnt + ONE;
                end
                default: d.st = FLD_RECOVER;
            endcase
            if (eof_done && (ev[4:0] == '0)) begin
                if (tx_active) ev[EV_TXOK] = 1'b1;
                else           ev[EV_RXOK] = 1'b1;
            end
            if (ev[4:0] != '0) begin
                d.st  = FLD_RECOVER;
                d.cnt = '0;
            end
        end
        d.evt    = ev;
        status_d = (status_q & ~clr_mask) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: FLD_IDLE, default: '0};
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        status_q <= status_d;
        rx_dlc_q <= rx_dlc_d;
    end

    assign evt    = q.evt;
    assign status = status_q;
    assign rx_dlc = rx_dlc_q;
endmodule

// File: rtl/can_frame_checker_chk.sv
module can_frame_checker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_valid,
    input logic       rx_bit,
    input logic       tx_active,
    input logic       tx_bit,
    input logic [7:0] clr_mask,
    input logic [7:0] evt,
    input logic [7:0] status
);
    p_ok_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt[6:5]));

    p_ok_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt[6:5]) |-> (evt[4:0] == 5'b0));

    p_evt_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |-> $past(bit_valid));

    p_status_holds_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status & evt) == evt);

    p_w1c_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & $past(clr_mask)) & ~evt) == 8'h00);

    p_bit_err_needs_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt[4] |-> ($past(tx_active) && ($past(tx_bit) != $past(rx_bit))));

    p_ack_err_recessive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |-> $past(rx_bit));

    p_form_err_dominant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt[1] |-> !$past(rx_bit));
endmodule

bind can_frame_checker can_frame_checker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .rx_bit    (rx_bit),
    .tx_active (tx_active),
    .tx_bit    (tx_bit),
    .clr_mask  (clr_mask),
    .evt       (evt),
    .status    (status)
);

// File: tb/can_frame_checker_tb_top.sv
`timescale 1ns/1ps
module can_frame_checker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       rx_bit = 1'b1;
    logic       tx_active = 1'b0;
    logic       tx_bit = 1'b1;
    logic [3:0] exp_dlc = 4'd0;
    logic [7:0] clr_mask = 8'h00;
    logic [7:0] evt, status;
    logic [3:0] rx_dlc;

    int checks = 0;
    int errors = 0;
    logic [7:0] last_evt;
    logic frm [0:191];
    int flen, slen;

    always #2 clk = ~clk;

    can_frame_checker dut_i (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rx_bit(rx_bit),
        .tx_active(tx_active), .tx_bit(tx_bit), .exp_dlc(exp_dlc),
        .clr_mask(clr_mask), .evt(evt), .status(status), .rx_dlc(rx_dlc)
    );

    // inj: 0 none, 1 bad CRC value, 2 CRC delimiter dominant, 3 ack slot recessive,
    //      4 ack delimiter dominant, 5 EOF bit dominant, 6 sent bit flipped at last CRC bit
    typedef struct packed {
        logic [10:0] id;
        logic        rtr;
        logic [3:0]  dlc;
        logic [63:0] data;
        logic [3:0]  edlc;
        logic        tx;
        logic [2:0]  inj;
        logic [7:0]  st;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{11'h123, 1'b0, 4'd2,  64'hA55A_0000_0000_0000, 4'd2,  1'b0, 3'd0, 8'h20},
        '{11'h7F0, 1'b0, 4'd8,  64'hFFFF_FFFF_0000_0000, 4'd8,  1'b0, 3'd0, 8'h20},
        '{11'h000, 1'b0, 4'd0,  64'h0,                   4'd0,  1'b0, 3'd0, 8'h20},
        '{11'h2AB, 1'b1, 4'd4,  64'hDEAD_BEEF_0000_0000, 4'd4,  1'b0, 3'd0, 8'h20},
        '{11'h555, 1'b0, 4'd12, 64'h0123_4567_89AB_CDEF, 4'd12, 1'b0, 3'd0, 8'h20},
        '{11'h111, 1'b0, 4'd3,  64'h00FF_7E00_0000_0000, 4'd5,  1'b0, 3'd0, 8'hA0},
        '{11'h3C3, 1'b0, 4'd1,  64'h8100_0000_0000_0000, 4'd1,  1'b1, 3'd0, 8'h40},
        '{11'h0F0, 1'b0, 4'd2,  64'h1234_0000_0000_0000, 4'd2,  1'b0, 3'd1, 8'h04},
        '{11'h0F1, 1'b0, 4'd1,  64'h5500_0000_0000_0000, 4'd1,  1'b0, 3'd2, 8'h02},
        '{11'h0F2, 1'b0, 4'd1,  64'hAA00_0000_0000_0000, 4'd1,  1'b0, 3'd3, 8'h01},
        '{11'h0F3, 1'b0, 4'd0,  64'h0,                   4'd0,  1'b0, 3'd4, 8'h02},
        '{11'h0F4, 1'b0, 4'd2,  64'hC3C3_0000_0000_0000, 4'd2,  1'b0, 3'd5, 8'h02},
        '{11'h6A5, 1'b0, 4'd2,  64'h0F0F_0000_0000_0000, 4'd2,  1'b1, 3'd6, 8'h10}
    };
    string vec_req [NV] = '{"R1", "R2", "R8", "R8", "R8", "R7", "R9",
                            "R3", "R4", "R5", "R4", "R4", "R6"};

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic feed(input logic rx, input logic ta, input logic tb);
        @(negedge clk);
        bit_valid = 1'b1; rx_bit = rx; tx_active = ta; tx_bit = tb;
        @(negedge clk);
        bit_valid = 1'b0;
        last_evt  = evt;
    endtask

    task automatic idle_bits(input int n);
        for (int k = 0; k < n; k++) feed(1'b1, 1'b0, 1'b1);
    endtask

    task automatic clear(input logic [7:0] m);
        @(negedge clk); clr_mask = m;
        @(negedge clk); clr_mask = 8'h00;
    endtask

    task automatic build(input logic [10:0] id, input logic rtr, input logic [3:0] dlc,
                         input logic [63:0] data, input logic crc_flip);
        logic u [0:127];
        int n = 0;
        int nb;
        logic [14:0] crc = '0;
        logic fb, last;
        int run;
        u[n] = 1'b0; n++;
        for (int i = 10; i >= 0; i--) begin u[n] = id[i]; n++; end
        u[n] = rtr; n++; u[n] = 1'b0; n++; u[n] = 1'b0; n++;
        for (int i = 3; i >= 0; i--) begin u[n] = dlc[i]; n++; end
        nb = rtr ? 0 : ((int'(dlc) > 8) ? 64 : int'(dlc) * 8);
        for (int k = 0; k < nb; k++) begin u[n] = data[63-k]; n++; end
        for (int k = 0; k < n; k++) begin
            fb  = u[k] ^ crc[14];
            crc = {crc[13:0], 1'b0};
            if (fb) crc = crc ^ 15'h4599;
        end
        if (crc_flip) crc[0] = ~crc[0];
        for (int i = 14; i >= 0; i--) begin u[n] = crc[i]; n++; end
        flen = 0; last = 1'b1; run = 0;
        for (int k = 0; k < n; k++) begin
            frm[flen] = u[k]; flen++;
            if (u[k] == last) run++;
            else begin run = 1; last = u[k]; end
            if (run == 5 && k < n - 1) begin
                frm[flen] = ~last; flen++;
                last = ~last; run = 1;
            end
        end
        slen = flen;
        frm[flen] = 1'b1; flen++;
        frm[flen] = 1'b0; flen++;
        for (int k = 0; k < 8; k++) begin frm[flen] = 1'b1; flen++; end
    endtask

    task automatic send(input logic tx, input int flip_idx, input int stop_idx);
        for (int k = 0; k < flen; k++) begin
            logic ta, tb;
            ta = tx && (k <= stop_idx);
            tb = frm[k];
            if (k == slen + 1) tb = 1'b1;
            if (k == flip_idx) tb = ~frm[k];
            feed(frm[k], ta, tb);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R10", 32'(evt), 32'h0, "evt in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", 32'(evt), 32'h0, "evt after reset");
        clear(8'hFF);
        @(negedge clk);
        chk("R11", 32'(status), 32'h0, "status after full clear");

        // R1: recessive bits while idle start nothing
        idle_bits(20);
        chk("R1", 32'(status), 32'h0, "status after idle bus");

        for (int v = 0; v < NV; v++) begin
            exp_dlc = VECS[v].edlc;
            build(VECS[v].id, VECS[v].rtr, VECS[v].dlc, VECS[v].data, VECS[v].inj == 3'd1);
            case (VECS[v].inj)
                3'd2: frm[slen]     = 1'b0;
                3'd3: frm[slen + 1] = 1'b1;
                3'd4: frm[slen + 2] = 1'b0;
                3'd5: frm[slen + 5] = 1'b0;
                default: ;
            endcase
            send(VECS[v].tx, (VECS[v].inj == 3'd6) ? slen - 1 : -1, 1000);
            idle_bits(11);
            @(negedge clk);
            chk(vec_req[v], 32'(status), 32'(VECS[v].st), "status after frame");
            chk("R7", 32'(rx_dlc), 32'(VECS[v].dlc), "received length");
            clear(8'hFF);
        end

        // R2 and R10: six dominant bits from idle, pulse lasts one cycle
        for (int k = 0; k < 6; k++) feed(1'b0, 1'b0, 1'b1);
        chk("R2", 32'(last_evt), 32'h08, "stuff error pulse");
        @(negedge clk);
        chk("R10", 32'(evt), 32'h0, "pulse gone next cycle");
        chk("R10", 32'(status), 32'h08, "sticky stuff flag");
        idle_bits(11);
        clear(8'hFF);

        // R6: sent recessive read dominant in identifier is lost arbitration
        exp_dlc = 4'd1;
        build(11'h0FF, 1'b0, 4'd1, 64'h3300_0000_0000_0000, 1'b0);
        send(1'b1, 1, 1);
        idle_bits(11);
        chk("R6", 32'(status), 32'h20, "arbitration loss not an error");
        clear(8'hFF);

        // R6: sent dominant read recessive in identifier is a bit error
        build(11'h400, 1'b0, 4'd1, 64'h3300_0000_0000_0000, 1'b0);
        send(1'b1, 1, 1000);
        idle_bits(11);
        chk("R6", 32'(status), 32'h10, "bit error inside identifier");
        clear(8'hFF);

        // R11: zero mask bits keep flags, one mask bits clear them
        build(11'h321, 1'b0, 4'd1, 64'h4200_0000_0000_0000, 1'b0);
        send(1'b0, -1, 1000);
        idle_bits(2);
        clear(8'h01);
        @(negedge clk);
        chk("R11", 32'(status), 32'h20, "unrelated clear keeps flag");
        clear(8'h20);
        @(negedge clk);
        chk("R11", 32'(status), 32'h0, "clear of set flag");

        // R12: ten recessive bits are not enough to leave recovery
        for (int k = 0; k < 6; k++) feed(1'b0, 1'b0, 1'b1);
        clear(8'hFF);
        idle_bits(10);
        build(11'h123, 1'b0, 4'd1, 64'h9900_0000_0000_0000, 1'b0);
        send(1'b0, -1, 1000);
        @(negedge clk);
        chk("R12", 32'(status), 32'h0, "frame ignored during recovery");
        idle_bits(11);
        send(1'b0, -1, 1000);
        idle_bits(11);
        chk("R12", 32'(status), 32'h20, "frame accepted after recovery");

        summary();
    end
endmodule